// File: doc/BRIEF.md
# External Interrupt Trigger Unit

This block conditions a small group of asynchronous interrupt pins before they reach an interrupt controller. Each pin is brought into the clock domain by a two-stage synchroniser. A per-pin trigger mode then decides which pin activity counts as an event: a rising edge, a falling edge, either edge, a high level or a low level. Events set a per-pin pending flag. The request line of a pin is raised only while its pending flag is set and its enable bit is on.

Software drives the unit through a 32-bit register window addressed by byte offset. One register packs a 4-bit trigger code for every pin. A second register holds the pending flags, and software clears a flag by writing a zero to its bit. A third register holds the request enables. A control word at offset 0x04 is part of the map but holds no state. A typical driver sets a pin to active-low level mode when it starts the pin, clears any stale pending state, and then sets the pin's enable.

Top module: `xirq_trigger_unit`

## Requirements
- R1: After reset, every register reads zero and all request outputs are low.
- R2: The mode register at offset 0x00 holds pin i's trigger code in bits [4i+3:4i]. It reads back what was written, and bits above the last pin read zero.
- R3: A pin change reaches the pending flag on the third rising clock edge after the change is sampled, because it passes through a two-flop synchroniser and one history flop.
- R4: Code 1 (rising edge) sets the pending flag on a low-to-high transition of the synchronised pin, and the flag stays set after the pin returns low.
- R5: Code 2 (falling edge) sets the pending flag on a high-to-low transition, and the flag is held.
- R6: Code 3 (both edges) sets the pending flag on either transition, and the flag is held.
- R7: In code 5 (high level) the pending flag equals the synchronised pin on every cycle. In code 6 (low level) it equals the inverse. Writes to the pending register have no lasting effect in these modes.
- R8: Code 0 and the reserved codes 4 and 7 to 15 keep the pending flag at zero whatever the pin does.
- R9: The pending register sits at offset 0x08, with bit i for pin i. In an edge mode, writing 0 to bit i clears that flag and writing 1 leaves it unchanged. An edge detected in the same cycle as a clearing write leaves the flag set.
- R10: The enable register sits at offset 0x0C, with bit i for pin i. Request output i is high exactly when pending bit i and enable bit i are both set.
- R11: The control word at offset 0x04 always reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 6 | Asynchronous external interrupt pins |
| busWrite | input | 1 | Register write strobe, one cycle per write |
| busAddr | input | 4 | Byte offset of the register being accessed |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irqOut | output | 6 | Per-pin request lines to the interrupt controller |

## Verification
The assertions assume that the pin inputs are stable around each rising clock edge once they have passed the first synchroniser stage. They also assume that a write strobe lasts exactly one cycle and carries a valid offset. The bench therefore changes pins and bus signals only shortly after the falling edge, holds each write for a single cycle, and uses only the four mapped offsets. Toggle patterns are spaced so that every detected edge comes from a real transition that has passed through synchronisation, including the cases where a clearing write lands in the same cycle as a new edge.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] TRIG_RISE = 4'd1;
  localparam logic [CODE_W-1:0] TRIG_FALL = 4'd2;
  localparam logic [CODE_W-1:0] TRIG_BOTH = 4'd3;
  localparam logic [CODE_W-1:0] TRIG_HIGH = 4'd5;
  localparam logic [CODE_W-1:0] TRIG_LOW  = 4'd6;

  localparam logic [3:0] OFF_MODE = 4'h0;
  localparam logic [3:0] OFF_CTRL = 4'h4;
  localparam logic [3:0] OFF_PEND = 4'h8;
  localparam logic [3:0] OFF_ENAB = 4'hC;

  typedef struct packed {
    logic modeWr;
    logic pendWr;
    logic enabWr;
  } strobe_t;
endpackage

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int DATA_W   = 32
) (
  input  logic                       busWrite,
  input  logic [3:0]                 busAddr,
  input  logic [NUM_PINS*CODE_W-1:0] modeQ,
  input  logic [NUM_PINS-1:0]        pendQ,
  input  logic [NUM_PINS-1:0]        enabQ,
  output strobe_t                    strobe,
  output logic [DATA_W-1:0]          busRdata
);
  always_comb begin
    strobe   = '0;
    busRdata = '0;
    case (busAddr)
      OFF_MODE: begin
        strobe.modeWr = busWrite;
        busRdata      = DATA_W'(modeQ);
      end
      OFF_PEND: begin
        strobe.pendWr = busWrite;
        busRdata      = DATA_W'(pendQ);
      end
      OFF_ENAB: begin
        strobe.enabWr = busWrite;
        busRdata      = DATA_W'(enabQ);
      end
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/xirq_datapath.sv
module xirq_datapath
  import xirq_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int DATA_W   = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PINS-1:0]        pinIn,
  input  strobe_t                    strobe,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_PINS*CODE_W-1:0] modeQ,
  output logic [NUM_PINS-1:0]        pendQ,
  output logic [NUM_PINS-1:0]        enabQ,
  output logic [NUM_PINS-1:0]        irqOut
);
  localparam int MODE_W = NUM_PINS * CODE_W;

  logic [NUM_PINS-1:0] syncA, syncB, syncPrev;
  logic [NUM_PINS-1:0] pendNext;

  function automatic logic nextFlag(input logic [CODE_W-1:0] code, input logic cur,
                                    input logic prev, input logic old, input logic keep);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (code)
      TRIG_RISE: nextFlag = (old & keep) | rise;
      TRIG_FALL: nextFlag = (old & keep) | fall;
      TRIG_BOTH: nextFlag = (old & keep) | rise | fall;
      TRIG_HIGH: nextFlag = cur;
      TRIG_LOW:  nextFlag = ~cur;
      default:   nextFlag = 1'b0;
    endcase
  endfunction

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      pendNext[i] = nextFlag(modeQ[i*CODE_W +: CODE_W], syncB[i], syncPrev[i], pendQ[i],
                             strobe.pendWr ? wdata[i] : 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
      modeQ    <= '0;
      pendQ    <= '0;
      enabQ    <= '0;
    end else begin
      syncA    <= pinIn;
      syncB    <= syncA;
      syncPrev <= syncB;
      pendQ    <= pendNext;
      if (strobe.modeWr) modeQ <= wdata[MODE_W-1:0];
      if (strobe.enabWr) enabQ <= wdata[NUM_PINS-1:0];
    end
  end

  assign irqOut = pendQ & enabQ;

  for (genvar g = 0; g < NUM_PINS; g++) begin : gChk
    logic [CODE_W-1:0] codeG;
    logic              edgeMode, idleMode;
    assign codeG    = modeQ[g*CODE_W +: CODE_W];
    assign edgeMode = (codeG == TRIG_RISE) || (codeG == TRIG_FALL) || (codeG == TRIG_BOTH);
    assign idleMode = !edgeMode && (codeG != TRIG_HIGH) && (codeG != TRIG_LOW);

    assert_idle_no_pend_R8: assert property (@(posedge clk) disable iff (!rstN)
      idleMode |=> !pendQ[g]);

    assert_level_follow_R7: assert property (@(posedge clk) disable iff (!rstN)
      (codeG == TRIG_HIGH) |=> (pendQ[g] == $past(syncB[g])));

    assert_edge_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
      (edgeMode && pendQ[g] && !strobe.pendWr) |=> pendQ[g]);

    assert_rise_source_R3: assert property (@(posedge clk) disable iff (!rstN)
      ((codeG == TRIG_RISE) && !pendQ[g] && !strobe.modeWr) |=>
        (!pendQ[g] || ($past(syncB[g]) && !$past(syncPrev[g]))));
  end
endmodule

// File: rtl/xirq_trigger_unit.sv
module xirq_trigger_unit
  import xirq_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                busWrite,
  input  logic [3:0]          busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic [NUM_PINS-1:0] irqOut
);
  localparam int MODE_W = NUM_PINS * CODE_W;

  strobe_t             strobe;
  logic [MODE_W-1:0]   modeQ;
  logic [NUM_PINS-1:0] pendQ, enabQ;

  xirq_ctrl #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_ctrl (
    .busWrite(busWrite), .busAddr(busAddr), .modeQ(modeQ), .pendQ(pendQ),
    .enabQ(enabQ), .strobe(strobe), .busRdata(busRdata)
  );

  xirq_datapath #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .strobe(strobe), .wdata(busWdata),
    .modeQ(modeQ), .pendQ(pendQ), .enabQ(enabQ), .irqOut(irqOut)
  );

  assert_ctrl_reads_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == OFF_CTRL) |-> (busRdata == '0));

  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut[0]) |-> (enabQ[0] && pendQ[0]));
endmodule

// File: tb/sim_xirq_trigger_unit.sv
`timescale 1ns/1ps
module sim_xirq_trigger_unit;
  localparam int N = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [N-1:0] pinIn = '0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = 4'h0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [N-1:0] irqOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string tag = "R1";

  int mMode[N];
  bit mPend[N];
  bit mEnab[N];
  logic [N-1:0] hist[$];

  always #4 clk = ~clk;

  xirq_trigger_unit u0 (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  // behavioural reference
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin mMode[i] = 0; mPend[i] = 0; mEnab[i] = 0; end
      hist = {6'd0, 6'd0, 6'd0};
    end else begin
      hist.push_back(pinIn);
      for (int i = 0; i < N; i++) begin
        bit cur, prv, keep;
        cur  = hist[hist.size()-3][i];
        prv  = hist[hist.size()-4][i];
        keep = (busWrite && busAddr == 4'h8) ? busWdata[i] : 1'b1;
        case (mMode[i])
          1: mPend[i] = (mPend[i] && keep) || (cur && !prv);
          2: mPend[i] = (mPend[i] && keep) || (!cur && prv);
          3: mPend[i] = (mPend[i] && keep) || (cur != prv);
          5: mPend[i] = cur;
          6: mPend[i] = !cur;
          default: mPend[i] = 0;
        endcase
      end
      if (busWrite && busAddr == 4'h0)
        for (int i = 0; i < N; i++) mMode[i] = (busWdata >> (4*i)) & 15;
      if (busWrite && busAddr == 4'hC)
        for (int i = 0; i < N; i++) mEnab[i] = busWdata[i];
      while (hist.size() > 8) void'(hist.pop_front());
    end
  end

  function automatic logic [31:0] modelRead(input logic [3:0] a);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < N; i++) begin
      case (a)
        4'h0: v = v | (32'(mMode[i]) << (4*i));
        4'h8: v[i] = mPend[i];
        4'hC: v[i] = mEnab[i];
        default: ;
      endcase
    end
    return v;
  endfunction

  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [N-1:0] expIrq;
      logic [31:0]  expRd;
      for (int i = 0; i < N; i++) expIrq[i] = mPend[i] && mEnab[i];
      expRd = modelRead(busAddr);
      checks++;
      if (irqOut !== expIrq) begin
        errors++;
        $display("FAIL %s irqOut actual=%h expected=%h t=%0t", tag, irqOut, expIrq, $time);
      end
      checks++;
      if (busRdata !== expRd) begin
        errors++;
        $display("FAIL %s rdata@%h actual=%h expected=%h t=%0t", tag, busAddr, busRdata, expRd, $time);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busWrite = 1'b1; busAddr = a; busWdata = d;
    cyc(1);
    busWrite = 1'b0; busAddr = 4'h8;
  endtask

  task automatic rd(input logic [3:0] a);
    busAddr = a;
    cyc(1);
  endtask

  task automatic pins(input logic [N-1:0] v, input int hold);
    pinIn = v;
    cyc(hold);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] lfsr;
    cyc(3);
    rstN = 1'b1;
    tag = "R1"; rd(4'h0); rd(4'h4); rd(4'h8); rd(4'hC);
    tag = "R2"; wr(4'h0, 32'hFFFB8740); rd(4'h0); wr(4'h0, 32'h00123456); rd(4'h0);
    tag = "R11"; wr(4'h4, 32'hFFFFFFFF); rd(4'h4); rd(4'h0); rd(4'h8); rd(4'hC);
    tag = "R3"; wr(4'h0, 32'h00111111); wr(4'hC, 32'h3F); wr(4'h8, 32'h0);
    pins(6'h01, 1); pins(6'h01, 1); pins(6'h01, 1); pins(6'h01, 2);
    tag = "R4"; pins(6'h00, 4); pins(6'h06, 5); pins(6'h00, 5);
    tag = "R9"; wr(4'h8, 32'h3E); cyc(2); wr(4'h8, 32'hFF); cyc(2);
    pins(6'h20, 2); wr(4'h8, 32'h00); cyc(3);
    pins(6'h00, 3); pins(6'h10, 1); wr(4'h8, 32'h00); cyc(4);
    tag = "R5"; wr(4'h0, 32'h00222222); wr(4'h8, 32'h0); pins(6'h3F, 5); pins(6'h2A, 5); pins(6'h3F, 5);
    wr(4'h8, 32'h0); cyc(3);
    tag = "R6"; wr(4'h0, 32'h00333333); wr(4'h8, 32'h0); pins(6'h05, 5); wr(4'h8, 32'h0);
    pins(6'h00, 5); wr(4'h8, 32'h0); pins(6'h30, 1); pins(6'h00, 5);
    tag = "R7"; wr(4'h0, 32'h00555555); pins(6'h2D, 4); pins(6'h12, 4); wr(4'h8, 32'h0); cyc(3);
    wr(4'h0, 32'h00666666); pins(6'h3C, 4); pins(6'h03, 4); wr(4'h8, 32'h0); pins(6'h00, 4);
    tag = "R8"; wr(4'h0, 32'h00FB8740); pins(6'h3F, 4); pins(6'h00, 4); pins(6'h3F, 4); rd(4'h8);
    tag = "R10"; wr(4'h0, 32'h00555555); wr(4'hC, 32'h15); pins(6'h3F, 4); wr(4'hC, 32'h2A); cyc(3);
    wr(4'hC, 32'h00); cyc(2); wr(4'hC, 32'h3F); pins(6'h09, 4);
    tag = "R9"; wr(4'h0, 32'h00653216); wr(4'h8, 32'h0);
    lfsr = 6'h2B;
    for (int k = 0; k < 120; k++) begin
      lfsr = {lfsr[4:0], lfsr[5] ^ lfsr[4]};
      pinIn = lfsr;
      if (k % 7 == 3) wr(4'h8, {26'd0, ~lfsr});
      else cyc(1);
    end
    tag = "R1"; rstN = 1'b0; cyc(2); rstN = 1'b1; rd(4'h0); rd(4'hC); rd(4'h8);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule